// File: doc/BRIEF.md
# Recovered-Data Lock Qualifier

This block decides when a clock-and-data-recovery path may report lock. It takes the recovered serial stream as one bit per clock, marked by a valid strobe. It cuts the stream into fixed windows of valid bits and counts two things in each window: level changes, and isolated bits, which are bits that differ from both neighbours. Data at the full line rate always has isolated bits. Data sent at half or quarter rate shows up at full rate as runs of two or four, so it has no isolated bits and fewer level changes. A window passes only when both counts reach their thresholds.

The window verdict drives a small qualification counter. Lock needs two passing windows in a row and falls after one failing window. Two pass flags from outside, one for frequency tolerance and one for eye opening, must both be high for lock to show. When either flag drops, lock clears in the same cycle and qualification starts over. A check-enable input can stop the window verdict from gating lock. This lets long-run test patterns lock, such as eight ones followed by eight zeros. Even then, the verdict of each window stays visible on a status output.

Top module: `lock_qual`

## Requirements
- R1: A window ends on the WIN_LEN-th valid bit. `win_done_o` is high for exactly the one cycle after the clock edge that sampled that bit.
- R2: Cycles with `bit_valid_i` low leave the window position, both counts and the bit history unchanged.
- R3: At the end of a window, `chk_pass_o` takes the window verdict. The verdict is 1 when the level changes in the window number at least MIN_TRANS and the isolated bits number at least MIN_SINGLES. Between window ends, `chk_pass_o` holds its value.
- R4: A level change is counted when a valid bit differs from the previous valid bit. An isolated bit is counted when the previous valid bit differs from both the bit before it and the current valid bit. Each event belongs to the window of the valid bit that completes it, and the bit history carries across window boundaries.
- R5: With both flags high, `lock_o` rises at the end of the second window in a row that qualifies.
- R6: With `chk_en_i` = 1, a window that fails the verdict clears lock at that window's end.
- R7: With `chk_en_i` = 0, every window qualifies whatever its verdict. The 8-ones/8-zeros pattern therefore reaches lock.
- R8: `chk_pass_o` reports the verdict even while `chk_en_i` = 0.
- R9: When `ppm_ok_i` or `eye_ok_i` is low, `lock_o` is 0 in the same cycle. Qualification then restarts, and after both flags return, two new qualifying windows are needed.
- R10: While `rst_ni` is low, `lock_o`, `chk_pass_o` and `win_done_o` are 0 and the bit history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | `bit_i` carries a recovered bit this cycle |
| bit_i | input | 1 | Recovered data bit |
| chk_en_i | input | 1 | 1: the transition verdict gates lock |
| ppm_ok_i | input | 1 | Frequency-tolerance pass flag |
| eye_ok_i | input | 1 | Eye-opening pass flag |
| lock_o | output | 1 | Lock may be declared |
| chk_pass_o | output | 1 | Verdict of the last completed window |
| win_done_o | output | 1 | One-cycle strobe after each window end |

## Verification
The assertions assume that `chk_en_i`, `ppm_ok_i` and `eye_ok_i` change only between clock edges and stay at known levels. They also assume that WIN_LEN is at least 2, so that two window ends can never fall in consecutive cycles. The bench changes every input at the falling edge, one cycle at a time, and the counts are its only gaps in valid bits. It drives full-rate, half-rate, quarter-rate and 8/8 patterns, plus a mixed pattern with a controlled number of isolated bits. Because every run has a length that is a multiple of the window, window boundaries stay aligned with the points where patterns change.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef struct packed {
    logic trans;   // level change completed by current bit
    logic single;  // previous bit confirmed isolated
  } edge_ev_t;
endpackage

// File: rtl/lq_edge_detect.sv
module lq_edge_detect
  import lq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  logic     bit_i,
  output edge_ev_t ev_o
);
  logic [1:0] hist_q;  // [0] newest
  logic [1:0] fill_q;

  always_comb begin
    ev_o.trans  = valid_i && (fill_q != 2'd0) && (bit_i != hist_q[0]);
    ev_o.single = valid_i && (fill_q == 2'd2) && (hist_q[0] != hist_q[1])
                  && (bit_i != hist_q[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      hist_q <= {hist_q[0], bit_i};
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end
endmodule

// File: rtl/lq_window.sv
module lq_window
  import lq_pkg::*;
#(
  parameter int WIN_LEN     = 1024,
  parameter int MIN_TRANS   = 64,
  parameter int MIN_SINGLES = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  edge_ev_t ev_i,
  output logic     eval_o,
  output logic     eval_pass_o,
  output logic     done_o,
  output logic     pass_o
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] pos_q, trans_q, single_q;
  logic [CW-1:0] trans_nx, single_nx;
  logic          done_q, pass_q;

  assign trans_nx    = trans_q + CW'(ev_i.trans);
  assign single_nx   = single_q + CW'(ev_i.single);
  assign eval_o      = valid_i && (pos_q == CW'(WIN_LEN - 1));
  assign eval_pass_o = (trans_nx >= CW'(MIN_TRANS)) && (single_nx >= CW'(MIN_SINGLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      trans_q  <= '0;
      single_q <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      done_q <= eval_o;
      if (eval_o) begin
        pos_q    <= '0;
        trans_q  <= '0;
        single_q <= '0;
        pass_q   <= eval_pass_o;
      end else if (valid_i) begin
        pos_q    <= pos_q + CW'(1);
        trans_q  <= trans_nx;
        single_q <= single_nx;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
endmodule

// File: rtl/lq_lock_fsm.sv
module lq_lock_fsm #(
  parameter int NEED_PASS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  input  logic eval_pass_i,
  input  logic chk_en_i,
  input  logic qual_ok_i,
  output logic lock_o
);
  localparam int SW = $clog2(NEED_PASS + 1);

  logic [SW-1:0] streak_q, streak_d;
  logic          win_ok;

  assign win_ok = eval_pass_i || !chk_en_i;

  always_comb begin
    streak_d = streak_q;
    if (!qual_ok_i)
      streak_d = '0;
    else if (eval_i) begin
      if (!win_ok)
        streak_d = '0;
      else if (streak_q != SW'(NEED_PASS))
        streak_d = streak_q + SW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) streak_q <= '0;
    else         streak_q <= streak_d;
  end

  // external flags clear lock without waiting for an edge
  assign lock_o = (streak_q == SW'(NEED_PASS)) && qual_ok_i;
endmodule

// File: rtl/lock_qual.sv
module lock_qual
  import lq_pkg::*;
#(
  parameter int WIN_LEN     = 1024,
  parameter int MIN_TRANS   = 64,
  parameter int MIN_SINGLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic chk_en_i,
  input  logic ppm_ok_i,
  input  logic eye_ok_i,
  output logic lock_o,
  output logic chk_pass_o,
  output logic win_done_o
);
  edge_ev_t ev;
  logic     eval, eval_pass;

  lq_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(bit_valid_i),
    .bit_i  (bit_i),
    .ev_o   (ev)
  );

  lq_window #(
    .WIN_LEN    (WIN_LEN),
    .MIN_TRANS  (MIN_TRANS),
    .MIN_SINGLES(MIN_SINGLES)
  ) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bit_valid_i),
    .ev_i       (ev),
    .eval_o     (eval),
    .eval_pass_o(eval_pass),
    .done_o     (win_done_o),
    .pass_o     (chk_pass_o)
  );

  lq_lock_fsm #(.NEED_PASS(2)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval),
    .eval_pass_i(eval_pass),
    .chk_en_i   (chk_en_i),
    .qual_ok_i  (ppm_ok_i && eye_ok_i),
    .lock_o     (lock_o)
  );
endmodule

// File: rtl/lock_qual_chk.sv
module lock_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_valid_i,
  input logic chk_en_i,
  input logic ppm_ok_i,
  input logic eye_ok_i,
  input logic lock_o,
  input logic chk_pass_o,
  input logic win_done_o
);
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_o |=> !win_done_o);

  p_idle_no_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !win_done_o);

  p_status_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done_o |-> $stable(chk_pass_o));

  p_lock_rise_at_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lock_o) && $stable(ppm_ok_i) && $stable(eye_ok_i)) |-> win_done_o);

  p_fail_drops_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && !chk_pass_o && $past(chk_en_i)) |-> !lock_o);

  p_flags_gate_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ppm_ok_i && eye_ok_i) |-> !lock_o);
endmodule

bind lock_qual lock_qual_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_valid_i(bit_valid_i),
  .chk_en_i   (chk_en_i),
  .ppm_ok_i   (ppm_ok_i),
  .eye_ok_i   (eye_ok_i),
  .lock_o     (lock_o),
  .chk_pass_o (chk_pass_o),
  .win_done_o (win_done_o)
);

// File: tb/lock_qual_tb.sv
module lock_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 64;
  localparam int MT = 16;
  localparam int MS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, bitv = 1'b0, en = 1'b1, ppm = 1'b1, eye = 1'b1;
  logic nx_en = 1'b1, nx_ppm = 1'b1, nx_eye = 1'b1;
  logic lock, chk_pass, win_done;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int  m_seen = 0, m_pos = 0, m_tr = 0, m_sg = 0, m_streak = 0;
  bit  m_p1 = 0, m_p2 = 0, m_pass = 0, m_done = 0;
  bit  q_bits[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_qual #(.WIN_LEN(W), .MIN_TRANS(MT), .MIN_SINGLES(MS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(valid), .bit_i(bitv),
    .chk_en_i(en), .ppm_ok_i(ppm), .eye_ok_i(eye),
    .lock_o(lock), .chk_pass_o(chk_pass), .win_done_o(win_done));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_lock();
    return (m_streak == 2) && ppm && eye;
  endfunction

  task automatic model_update();
    bit ev_t, ev_s;
    m_done = 0;
    if (valid) begin
      ev_t = (m_seen >= 1) && (bitv != m_p1);
      ev_s = (m_seen >= 2) && (m_p1 != m_p2) && (bitv != m_p1);
      m_tr += int'(ev_t);
      m_sg += int'(ev_s);
      m_p2 = m_p1; m_p1 = bitv; m_seen++;
      if (m_pos == W-1) begin
        m_done = 1;
        m_pass = (m_tr >= MT) && (m_sg >= MS);
        m_pos = 0; m_tr = 0; m_sg = 0;
      end else m_pos++;
    end
    if (!(ppm && eye)) m_streak = 0;
    else if (m_done) m_streak = (m_pass || !en) ? ((m_streak < 2) ? m_streak + 1 : 2) : 0;
  endtask

  task automatic step(input logic v, input logic b);
    @(negedge clk);
    check("R1 win_done_o", win_done, m_done);
    check("R3 chk_pass_o", chk_pass, m_pass);
    check("R5 lock_o", lock, exp_lock());
    valid = v; bitv = b; en = nx_en; ppm = nx_ppm; eye = nx_eye;
    model_update();
  endtask

  function automatic bit gen(input int kind, input int i);
    case (kind)
      0: return bit'(i % 2);
      1: return bit'((i / 2) % 2);
      2: return bit'((i / 4) % 2);
      default: return bit'(((i / 8) % 2) == 0);
    endcase
  endfunction

  task automatic run(input int kind, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) step(1'b0, 1'b1);
      step(1'b1, gen(kind, i));
    end
  endtask

  task automatic settle();
    step(1'b0, 1'b0);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 lock reset", lock, 1'b0);
    check("R10 pass reset", chk_pass, 1'b0);
    check("R10 done reset", win_done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // full-rate alternating data qualifies
    run(0, 3 * W, 0);
    settle();
    check("R5 lock after two passes", lock, 1'b1);
    check("R3 alt passes", chk_pass, 1'b1);

    // half-rate look-alike fails
    run(1, 2 * W, 0);
    settle();
    check("R3 half-rate rejected", chk_pass, 1'b0);
    check("R6 lock dropped", lock, 1'b0);

    // quarter-rate look-alike fails
    run(2, 2 * W, 0);
    settle();
    check("R3 quarter-rate rejected", chk_pass, 1'b0);

    // 8/8 square wave: blocked with check on, locks with check off
    run(3, 2 * W, 0);
    settle();
    check("R6 square blocked", lock, 1'b0);
    nx_en = 1'b0;
    settle();
    run(3, 2 * W, 0);
    settle();
    check("R7 square locks with check off", lock, 1'b1);
    check("R8 verdict still reported", chk_pass, 1'b0);

    // gaps in valid do not advance the window
    nx_en = 1'b1;
    run(1, W, 0);
    settle();
    check("R6 fail drops lock", lock, 1'b0);
    run(0, W, 1);
    settle();
    check("R2 one window after gapped bits", lock, 1'b0);
    run(0, W, 1);
    settle();
    check("R2 gapped bits lock after two", lock, 1'b1);

    // flag drops clear lock at once and restart qualification
    nx_ppm = 1'b0;
    settle();
    check("R9 ppm drop clears lock", lock, 1'b0);
    nx_ppm = 1'b1;
    run(0, W, 0);
    settle();
    check("R9 one window not enough", lock, 1'b0);
    run(0, W, 0);
    settle();
    check("R9 relock after two", lock, 1'b1);
    nx_eye = 1'b0;
    settle();
    check("R9 eye drop clears lock", lock, 1'b0);
    nx_eye = 1'b1;
    settle();
    check("R9 no relock on flag return", lock, 1'b0);

    // isolated-bit threshold: runs of two with injected singles
    for (int k = MS - 1; k <= MS; k++) begin
      q_bits.delete();
      for (int j = 0; j < k; j++) begin
        q_bits.push_back(1'b1); q_bits.push_back(1'b0);
        q_bits.push_back(1'b0); q_bits.push_back(1'b1);
        q_bits.push_back(1'b1); q_bits.push_back(1'b0);
        q_bits.push_back(1'b0);
      end
      while (q_bits.size() < W) q_bits.push_back(bit'((q_bits.size() / 2) % 2));
      foreach (q_bits[i]) step(1'b1, q_bits[i]);
      settle();
      check("R4 isolated-bit count verdict", chk_pass, m_pass);
    end

    run(0, W, 0);
    settle();
    finish_run();
  end
endmodule